// File: doc/BRIEF.md
# Tile Damage Repair Sequencer

This block handles one renderer's part of the screen when an object is deleted from the scene. It holds a small store of polygon fragments. Each fragment has already been clipped to one tile and carries the ID of the object it belongs to. The renderer owns a fixed subset of the tiles and repairs only those tiles, with no exchange with other renderers.

A delete command names an object. The sequencer then works through the tiles that object touched, one tile at a time. For each tile it runs three steps in order:

1. It streams depth writes that set every location of the tile to the largest 24-bit depth.
2. It drops the deleted object's fragments of that tile from the store.
3. It replays the remaining fragments of that tile to a downstream rasteriser over a valid/ready port.

No other tile is cleared or redrawn.

Fragments are loaded through a simple port while the block is idle. A fragment for a tile that another renderer owns is dropped.

Top module: `tile_repair_seq`

## Requirements
- R1: After reset, busy, done, zw_valid and rp_valid are 0, and del_ready is 1.
- R2: A fragment load is stored only when its tile index modulo NUM_REN equals RENDERER_ID. A load for any other tile is ignored, so a later delete of that object produces no depth writes and no replays.
- R3: frag_ready is 1 only when the block is idle and at least one store slot is free. A load is taken on a cycle with frag_valid and frag_ready both high, and it goes into the lowest-numbered free slot.
- R4: For each affected tile t, the block issues exactly 2^(2*SIDE_LOG) depth writes. With the default SIDE_LOG of 2 that is 16 writes, at zw_addr = {t, k} for k counting up from 0. Each write has zw_data equal to all ones (24'hFFFFFF).
- R5: Fragments of the deleted object are never replayed and are removed from the store. A second delete of the same object therefore finds nothing.
- R6: After the depth clear of tile t, every surviving fragment of tile t is replayed once, in ascending slot order. Fragments of other tiles are not replayed.
- R7: Tiles are repaired one at a time. Tile order follows the lowest slot that still holds a fragment of the deleted object. For each tile, all depth writes come before any replay of that tile. The two streams are never valid in the same cycle.
- R8: A delete is accepted when del_valid and del_ready are both high. From the next cycle, busy is 1 and del_ready is 0. Busy stays high until after the last replay of the last tile has been accepted. Done is then a one-cycle pulse, and busy is 0 in the done cycle.
- R9: A delete of an object with no stored fragments ends with a done pulse and produces no depth writes and no replays.
- R10: While zw_valid or rp_valid is high and its ready input is low, the valid signal and its payload hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frag_valid | input | 1 | Fragment load request |
| frag_ready | output | 1 | Idle with a free slot |
| frag_obj | input | OBJ_W | Object ID of the loaded fragment |
| frag_tile | input | TILE_W | Tile index of the loaded fragment |
| frag_data | input | DATA_W | Fragment payload handle |
| del_valid | input | 1 | Delete command request |
| del_ready | output | 1 | Delete command can be taken |
| del_obj | input | OBJ_W | Object to delete |
| busy | output | 1 | Repair in progress |
| done | output | 1 | One-cycle repair-finished pulse |
| zw_valid | output | 1 | Depth write request |
| zw_ready | input | 1 | Depth memory accepts the write |
| zw_addr | output | TILE_W+2*SIDE_LOG | Depth address, {tile, pixel} |
| zw_data | output | Z_W | Depth value written |
| rp_valid | output | 1 | Replayed fragment valid |
| rp_ready | input | 1 | Rasteriser accepts the fragment |
| rp_obj | output | OBJ_W | Object ID of the replayed fragment |
| rp_tile | output | TILE_W | Tile of the replayed fragment |
| rp_data | output | DATA_W | Payload of the replayed fragment |

## Verification
Faults in internal state show up at the ports within one tile's repair:

- A wrong store entry or a missed purge shows as an extra, missing or misordered replay right after that tile's depth clear.
- A counter fault in the clear generator shows as a wrong address or a wrong write count on the depth stream.
- A sequencer state fault shows as busy falling early or a missing done pulse.

Each delete is compared, event by event, against a list built from a model of slot allocation. Random ready stalls are applied to the depth and replay streams to expose payloads that change while stalled.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SCAN  = 3'd1,
    S_ZCLR  = 3'd2,
    S_PURGE = 3'd3,
    S_RPLY  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/frag_store.sv
module frag_store #(
  parameter int DEPTH  = 16,
  parameter int OBJ_W  = 6,
  parameter int TILE_W = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [OBJ_W-1:0]  ld_obj,
  input  logic [TILE_W-1:0] ld_tile,
  input  logic [DATA_W-1:0] ld_data,
  output logic              has_free,
  input  logic [OBJ_W-1:0]  key_obj,
  output logic              hit,
  output logic [TILE_W-1:0] hit_tile,
  input  logic              pg_en,
  input  logic [TILE_W-1:0] pg_tile,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [OBJ_W-1:0]  rd_obj,
  output logic [TILE_W-1:0] rd_tile,
  output logic [DATA_W-1:0] rd_data
);
  logic [DEPTH-1:0]  vld;
  logic [OBJ_W-1:0]  s_obj  [DEPTH];
  logic [TILE_W-1:0] s_tile [DEPTH];
  logic [DATA_W-1:0] s_data [DEPTH];
  logic [DEPTH-1:0]  key_m;
  logic [IDX_W-1:0]  free_idx;

  always_comb begin
    free_idx = '0;
    hit_tile = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IDX_W'(i);
      if (key_m[i]) hit_tile = s_tile[i];
    end
  end

  assign has_free = ~&vld;
  assign hit      = |key_m;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      assign key_m[g] = vld[g] && (s_obj[g] == key_obj);
      always_ff @(posedge clk) begin
        if (rst) begin
          vld[g] <= 1'b0;
        end else if (ld_en && free_idx == IDX_W'(g)) begin
          vld[g] <= 1'b1;
        end else if (pg_en && key_m[g] && s_tile[g] == pg_tile) begin
          vld[g] <= 1'b0;
        end
      end
      always_ff @(posedge clk) begin
        if (ld_en && free_idx == IDX_W'(g)) begin
          s_obj[g]  <= ld_obj;
          s_tile[g] <= ld_tile;
          s_data[g] <= ld_data;
        end
      end
    end
  endgenerate

  assign rd_vld  = vld[rd_idx];
  assign rd_obj  = s_obj[rd_idx];
  assign rd_tile = s_tile[rd_idx];
  assign rd_data = s_data[rd_idx];

  // R3
  ld_no_full_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |-> has_free);

  // R5
  purge_gone_chk: assert property (@(posedge clk) disable iff (rst)
    pg_en |=> !(hit && hit_tile == $past(pg_tile) && key_obj == $past(key_obj)));
endmodule

// File: rtl/zclear_gen.sv
module zclear_gen #(
  parameter int TILE_W   = 6,
  parameter int SIDE_LOG = 2,
  parameter int Z_W      = 24,
  localparam int PIX_W   = 2 * SIDE_LOG,
  localparam int ZA_W    = TILE_W + PIX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TILE_W-1:0] tile,
  input  logic              ready,
  output logic              valid,
  output logic [ZA_W-1:0]   addr,
  output logic [Z_W-1:0]    data,
  output logic              fin
);
  logic [PIX_W-1:0]  cnt;
  logic [TILE_W-1:0] tile_q;

  assign addr = {tile_q, cnt};
  assign data = {Z_W{1'b1}};
  assign fin  = valid && ready && (cnt == {PIX_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      cnt    <= '0;
      tile_q <= '0;
    end else if (start && !valid) begin
      valid  <= 1'b1;
      cnt    <= '0;
      tile_q <= tile;
    end else if (valid && ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == {PIX_W{1'b1}}) valid <= 1'b0;
    end
  end

  // R4
  zw_step_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && ready && addr[PIX_W-1:0] != {PIX_W{1'b1}})
      |=> (valid && addr == ZA_W'($past(addr) + 1'b1)));

  // R10
  zw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(addr)));
endmodule

// File: rtl/tile_repair_seq.sv
module tile_repair_seq
  import tdr_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OBJ_W       = 6,
  parameter int TILE_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SIDE_LOG    = 2,
  parameter int Z_W         = 24,
  parameter int NUM_REN     = 4,
  parameter int RENDERER_ID = 0,
  localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ZA_W       = TILE_W + 2 * SIDE_LOG,
  localparam int REN_W      = (NUM_REN > 1) ? $clog2(NUM_REN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frag_valid,
  output logic              frag_ready,
  input  logic [OBJ_W-1:0]  frag_obj,
  input  logic [TILE_W-1:0] frag_tile,
  input  logic [DATA_W-1:0] frag_data,
  input  logic              del_valid,
  output logic              del_ready,
  input  logic [OBJ_W-1:0]  del_obj,
  output logic              busy,
  output logic              done,
  output logic              zw_valid,
  input  logic              zw_ready,
  output logic [ZA_W-1:0]   zw_addr,
  output logic [Z_W-1:0]    zw_data,
  output logic              rp_valid,
  input  logic              rp_ready,
  output logic [OBJ_W-1:0]  rp_obj,
  output logic [TILE_W-1:0] rp_tile,
  output logic [DATA_W-1:0] rp_data
);
  localparam logic [REN_W-1:0] RID  = REN_W'(RENDERER_ID);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  seq_state_t        st;
  logic [OBJ_W-1:0]  tgt;
  logic [TILE_W-1:0] cur_tile;
  logic [IDX_W-1:0]  ptr;
  logic              owned, has_free, ld_en;
  logic              hit, zc_start, zc_fin, pg_en;
  logic [TILE_W-1:0] hit_tile;
  logic              rd_vld;
  logic [OBJ_W-1:0]  rd_obj;
  logic [TILE_W-1:0] rd_tile;
  logic [DATA_W-1:0] rd_data;
  logic              rd_match;

  assign owned      = (frag_tile[REN_W-1:0] == RID) || (NUM_REN == 1);
  assign frag_ready = (st == S_IDLE) && has_free;
  assign ld_en      = frag_valid && frag_ready && owned;
  assign del_ready  = (st == S_IDLE);
  assign busy       = (st != S_IDLE);
  assign zc_start   = (st == S_SCAN) && hit;
  assign pg_en      = (st == S_PURGE);
  assign rd_match   = rd_vld && (rd_tile == cur_tile);

  frag_store #(
    .DEPTH(DEPTH), .OBJ_W(OBJ_W), .TILE_W(TILE_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .ld_en(ld_en), .ld_obj(frag_obj), .ld_tile(frag_tile), .ld_data(frag_data),
    .has_free(has_free),
    .key_obj(tgt), .hit(hit), .hit_tile(hit_tile),
    .pg_en(pg_en), .pg_tile(cur_tile),
    .rd_idx(ptr), .rd_vld(rd_vld), .rd_obj(rd_obj), .rd_tile(rd_tile),
    .rd_data(rd_data)
  );

  zclear_gen #(
    .TILE_W(TILE_W), .SIDE_LOG(SIDE_LOG), .Z_W(Z_W)
  ) u_zclr (
    .clk(clk), .rst(rst), .start(zc_start), .tile(hit_tile),
    .ready(zw_ready), .valid(zw_valid), .addr(zw_addr), .data(zw_data),
    .fin(zc_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      tgt      <= '0;
      cur_tile <= '0;
      ptr      <= '0;
      done     <= 1'b0;
      rp_valid <= 1'b0;
      rp_obj   <= '0;
      rp_tile  <= '0;
      rp_data  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (del_valid) begin
          tgt <= del_obj;
          st  <= S_SCAN;
        end
        S_SCAN: if (hit) begin
          cur_tile <= hit_tile;
          st       <= S_ZCLR;
        end else begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        S_ZCLR: if (zc_fin) st <= S_PURGE;
        S_PURGE: begin
          ptr <= '0;
          st  <= S_RPLY;
        end
        S_RPLY: begin
          if (rp_valid) begin
            if (rp_ready) begin
              rp_valid <= 1'b0;
              if (ptr == LAST) st <= S_SCAN;
              else ptr <= ptr + 1'b1;
            end
          end else if (rd_match) begin
            rp_valid <= 1'b1;
            rp_obj   <= rd_obj;
            rp_tile  <= rd_tile;
            rp_data  <= rd_data;
          end else if (ptr == LAST) begin
            st <= S_SCAN;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  rp_not_deleted_chk: assert property (@(posedge clk) disable iff (rst)
    rp_valid |-> (rp_obj != tgt));

  // R6
  rp_tile_chk: assert property (@(posedge clk) disable iff (rst)
    rp_valid |-> (rp_tile == cur_tile));

  // R7
  stream_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(zw_valid && rp_valid));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(del_valid && del_ready));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  rp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rp_valid && !rp_ready) |=> (rp_valid && $stable({rp_obj, rp_tile, rp_data})));
endmodule

// File: tb/tb_tile_repair_seq.sv
`timescale 1ns/1ps
module tb_tile_repair_seq;
  localparam int DEPTH = 8, OBJ_W = 6, TILE_W = 6, DATA_W = 16;
  localparam int SIDE_LOG = 2, Z_W = 24, NUM_REN = 4, RID = 2;
  localparam int ZA_W = TILE_W + 2 * SIDE_LOG;
  localparam int PIX = 1 << (2 * SIDE_LOG);

  logic clk = 0, rst = 1;
  logic frag_valid = 0, del_valid = 0, zw_ready = 1, rp_ready = 1;
  logic [OBJ_W-1:0] frag_obj = 0, del_obj = 0;
  logic [TILE_W-1:0] frag_tile = 0;
  logic [DATA_W-1:0] frag_data = 0;
  logic frag_ready, del_ready, busy, done, zw_valid, rp_valid;
  logic [ZA_W-1:0] zw_addr;
  logic [Z_W-1:0] zw_data;
  logic [OBJ_W-1:0] rp_obj;
  logic [TILE_W-1:0] rp_tile;
  logic [DATA_W-1:0] rp_data;

  tile_repair_seq #(.DEPTH(DEPTH), .OBJ_W(OBJ_W), .TILE_W(TILE_W), .DATA_W(DATA_W),
    .SIDE_LOG(SIDE_LOG), .Z_W(Z_W), .NUM_REN(NUM_REN), .RENDERER_ID(RID)) dut (
    .clk(clk), .rst(rst), .frag_valid(frag_valid), .frag_ready(frag_ready),
    .frag_obj(frag_obj), .frag_tile(frag_tile), .frag_data(frag_data),
    .del_valid(del_valid), .del_ready(del_ready), .del_obj(del_obj),
    .busy(busy), .done(done), .zw_valid(zw_valid), .zw_ready(zw_ready),
    .zw_addr(zw_addr), .zw_data(zw_data), .rp_valid(rp_valid), .rp_ready(rp_ready),
    .rp_obj(rp_obj), .rp_tile(rp_tile), .rp_data(rp_data));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic m_v [DEPTH];
  logic [OBJ_W-1:0] m_obj [DEPTH];
  logic [TILE_W-1:0] m_tile [DEPTH];
  logic [DATA_W-1:0] m_data [DEPTH];

  int ev_n = 0, ex_n = 0;
  logic [1:0]  ev_k [512];
  logic [31:0] ev_v [512];
  logic [1:0]  ex_k [512];
  logic [31:0] ex_v [512];

  logic stall_on = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic pz_st = 0, pr_st = 0;
  logic [ZA_W-1:0] pz_a;
  logic [31:0] pr_p;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk); #2;
    if (stall_on) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      zw_ready = lfsr[0] | lfsr[3];
      rp_ready = lfsr[5];
    end else begin
      zw_ready = 1; rp_ready = 1;
    end
  end

  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (pz_st) chk(zw_valid && zw_addr == pz_a, "R10 zw hold", {22'd0, zw_addr}, {22'd0, pz_a});
      if (pr_st) chk(rp_valid && {rp_obj, rp_tile, rp_data} == pr_p[27:0], "R10 rp hold",
                     {4'd0, rp_obj, rp_tile, rp_data}, pr_p);
      pz_st = zw_valid && !zw_ready; pz_a = zw_addr;
      pr_st = rp_valid && !rp_ready; pr_p = {4'd0, rp_obj, rp_tile, rp_data};
      if (zw_valid && zw_ready && ev_n < 512) begin
        ev_k[ev_n] = 1; ev_v[ev_n] = {8'd0, zw_data[23:0]} ^ 32'hFFFFFF ^ {22'd0, zw_addr};
        ev_n++;
      end
      if (rp_valid && rp_ready && ev_n < 512) begin
        ev_k[ev_n] = 2; ev_v[ev_n] = {4'd0, rp_obj, rp_tile, rp_data}; ev_n++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic load(input int o, input int t, input int d);
    bit acc, own, fr;
    int fi;
    @(negedge clk);
    frag_valid = 1; frag_obj = OBJ_W'(o); frag_tile = TILE_W'(t); frag_data = DATA_W'(d);
    fi = -1;
    for (int i = DEPTH - 1; i >= 0; i--) if (!m_v[i]) fi = i;
    fr = frag_ready;
    chk(fr == (fi >= 0), "R3 frag_ready", {31'd0, fr}, {31'd0, fi >= 0});
    own = (t % NUM_REN) == RID;
    acc = fr && own;
    if (acc) begin
      m_v[fi] = 1; m_obj[fi] = OBJ_W'(o); m_tile[fi] = TILE_W'(t); m_data[fi] = DATA_W'(d);
    end
    @(negedge clk);
    frag_valid = 0;
  endtask

  task automatic build_exp(input int o);
    int s;
    logic [TILE_W-1:0] t;
    ex_n = 0;
    forever begin
      s = -1;
      for (int i = DEPTH - 1; i >= 0; i--) if (m_v[i] && m_obj[i] == OBJ_W'(o)) s = i;
      if (s < 0) break;
      t = m_tile[s];
      for (int k = 0; k < PIX; k++) begin
        ex_k[ex_n] = 1; ex_v[ex_n] = {22'd0, t, 4'(k)}; ex_n++;
      end
      for (int i = 0; i < DEPTH; i++)
        if (m_v[i] && m_obj[i] == OBJ_W'(o) && m_tile[i] == t) m_v[i] = 0;
      for (int i = 0; i < DEPTH; i++)
        if (m_v[i] && m_tile[i] == t) begin
          ex_k[ex_n] = 2; ex_v[ex_n] = {4'd0, m_obj[i], m_tile[i], m_data[i]}; ex_n++;
        end
    end
  endtask

  task automatic delete_obj(input int o, input string req);
    int cyc, bad_busy, mis;
    build_exp(o);
    @(negedge clk);
    ev_n = 0;
    chk(del_ready, {req, " R8 idle ready"}, {31'd0, del_ready}, 1);
    del_valid = 1; del_obj = OBJ_W'(o);
    @(negedge clk);
    del_valid = 0;
    chk(busy && !del_ready, {req, " R8 busy after accept"}, {30'd0, busy, del_ready}, 2);
    cyc = 0; bad_busy = 0;
    while (!done && cyc < 5000) begin
      if (!busy || del_ready || frag_ready) bad_busy++;
      @(negedge clk); cyc++;
    end
    chk(done && !busy, {req, " R8 done pulse"}, {30'd0, done, busy}, 2);
    chk(bad_busy == 0, {req, " R8 busy held"}, bad_busy, 0);
    chk(ev_n == ex_n, {req, " event count"}, ev_n, ex_n);
    mis = 0;
    for (int i = 0; i < ex_n && i < ev_n; i++)
      if (ev_k[i] != ex_k[i] || ev_v[i] != ex_v[i]) mis++;
    chk(mis == 0, {req, " event order/content"}, mis, 0);
    @(negedge clk);
    chk(!done && !busy, {req, " R8 done one cycle"}, {30'd0, done, busy}, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !zw_valid && !rp_valid && del_ready, "R1 reset",
        {27'd0, busy, done, zw_valid, rp_valid, del_ready}, 1);
  endtask

  task automatic t_basic;
    load(1, 2, 16'hA1); load(2, 2, 16'hB2); load(1, 6, 16'hC3); load(3, 6, 16'hD4);
    load(7, 3, 16'hE5); load(2, 10, 16'hF6); load(1, 2, 16'hA7);
    delete_obj(1, "R4 R6 R7 basic");
  endtask

  task automatic t_again;
    delete_obj(1, "R5 R9 repeat");
    delete_obj(9, "R9 unknown");
    delete_obj(7, "R2 foreign tile");
  endtask

  task automatic t_stall;
    load(4, 14, 16'h1111); load(2, 14, 16'h2222); load(4, 10, 16'h3333);
    stall_on = 1;
    delete_obj(2, "R10 R6 stalled");
    stall_on = 0;
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH + 2; i++) load(5, 6 + 4 * (i % 3), 16'h500 + 16'(i));
    delete_obj(5, "R3 R6 full store");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_again();
    t_stall();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule